// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a supervisory timer that a processor must keep restarting. A 16-bit up-counter advances on the ticks of one of two clock-enable inputs. Each interval setting has a fixed terminal tick count. When the counter reaches that count, the block drives a one-cycle pulse on either a system reset output or a non-maskable interrupt output. A mode bit picks which. The counter then starts again from zero.

The only software-visible register is a 16-bit control word. A write changes it only when the upper byte carries the key value 8'h5A. A write with any other upper byte leaves the register untouched. Such a write pulses a key-violation flag and fires the same reset or interrupt action as an expiry. Software restarts the timer with a keyed write that sets the clear bit. Reads never return the key. The upper byte of every read is 8'h69.

Control byte layout (bits [7:0] of a write):
- bit 7: hold. 1 freezes the counter.
- bit 4: action. 0 selects reset, 1 selects interrupt.
- bit 3: clear. Write-only; it restarts the counter.
- bit 2: source. 0 selects source A, 1 selects source B.
- bits [1:0]: interval.
- bits 6 and 5: reserved.

Top module: `kwdTimer`

## Requirements
- R1: After reset, rdData reads 16'h6900 and all three outputs are low. The timer runs from source A in reset mode with interval 0, which is 2^TAP_E0 ticks (the largest interval).
- R2: rdData is always {8'h69, hold, 1'b0, 1'b0, action, 1'b0, source, interval[1:0]}. The clear bit and the reserved bits read as 0.
- R3: A write whose bits [15:8] equal 8'h5A loads hold (bit 7), action (bit 4), source (bit 2) and interval (bits [1:0]) from bits [7:0].
- R4: A write whose bits [15:8] differ from 8'h5A leaves the control register unchanged. It drives keyViol high for exactly the one cycle after the write edge.
- R5: A wrong-key write also pulses rstOut when action is 0, or nmiOut when action is 1, in the same cycle as keyViol.
- R6: The counter advances only on ticks of the selected source: srcAEn when source is 0, srcBEn when source is 1. Ticks on the other input have no effect.
- R7: Interval codes 0, 1, 2 and 3 give terminal counts of 2^TAP_E0, 2^TAP_E1, 2^TAP_E2 and 2^TAP_E3 ticks. The action pulse appears in the cycle right after the edge of the terminal tick, counted from the last clear.
- R8: An expiry pulses rstOut (action 0) or nmiOut (action 1) for exactly one cycle. The counter then restarts, so the next expiry comes after the same number of further ticks.
- R9: A keyed write with bit 3 set returns the counter to zero. A tick in that same cycle is not counted.
- R10: While hold is 1, ticks do not change the counter and no expiry occurs. Clearing hold resumes counting from the held value.
- R11: rstOut and nmiOut are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcAEn | input | 1 | Tick enable of source A |
| srcBEn | input | 1 | Tick enable of source B |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 16 | Write word: key in [15:8], control in [7:0] |
| rdData | output | 16 | Read word: 8'h69 and the control byte |
| rstOut | output | 1 | One-cycle system reset request |
| nmiOut | output | 1 | One-cycle non-maskable interrupt request |
| keyViol | output | 1 | One-cycle wrong-key indication |

## Verification
A wrong count or a stuck terminal compare moves the action pulse away from tick N after a clear. The error shows as soon as the first expiry of a sweep run. A wrong restart value shows up at the second expiry, which must come at 2N. A control register corrupted by a bad key shows on rdData one cycle after the write. A counter that moved during hold, or on the unselected source, shows as an early pulse once counting resumes.

// File: rtl/kwdPkg.sv
package kwdPkg;

  // Bit positions inside the control byte.
  localparam int HOLD_BIT = 7;
  localparam int ACT_BIT  = 4;
  localparam int CLR_BIT  = 3;
  localparam int SRC_BIT  = 2;

  // Strobes and settings sent from the control unit to the counter.
  typedef struct packed {
    logic       clrCnt;
    logic       runEn;
    logic       useSrcB;
    logic [1:0] ivlSel;
  } cntCtl_t;

endpackage

// File: rtl/kwdCount.sv
module kwdCount
  import kwdPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TAP_E0 = 15,
  parameter int TAP_E1 = 13,
  parameter int TAP_E2 = 9,
  parameter int TAP_E3 = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    srcAEn,
  input  logic    srcBEn,
  input  cntCtl_t ctl,
  output logic    expire
);

  localparam int NUM_TAPS = 4;
  localparam int TAP_E[NUM_TAPS] = '{TAP_E0, TAP_E1, TAP_E2, TAP_E3};

  logic [CNT_W-1:0] tapLast [NUM_TAPS];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;
  logic             tick;
  logic             step;
  logic             atLast;

  // Each interval code has its own terminal value: 2^E - 1.
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tapLast[i] = CNT_W'((64'd1 << TAP_E[i]) - 64'd1);
  end

  assign lastVal = tapLast[ctl.ivlSel];
  assign tick    = ctl.useSrcB ? srcBEn : srcAEn;
  assign step    = tick & ctl.runEn;
  // The >= compare also covers a counter left above a newly chosen shorter interval.
  assign atLast  = (cnt >= lastVal);
  assign expire  = step & ~ctl.clrCnt & atLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clrCnt) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= atLast ? '0 : cnt + 1'b1;
    end
  end

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCnt |=> (cnt == '0));

  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !ctl.clrCnt) |=> $stable(cnt));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cnt == '0));

  // R6
  no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctl.clrCnt) |=> $stable(cnt));

endmodule

// File: rtl/kwdCtrl.sv
module kwdCtrl
  import kwdPkg::*;
#(
  parameter logic [7:0] KEY_CODE = 8'h5A,
  parameter logic [7:0] READ_TAG = 8'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        expire,
  output cntCtl_t     ctl,
  output logic [15:0] rdData,
  output logic        rstOut,
  output logic        nmiOut,
  output logic        keyViol
);

  logic       holdQ;
  logic       actQ;
  logic       srcQ;
  logic [1:0] ivlQ;
  logic       keyOk;
  logic       goodWr;
  logic       badWr;
  logic       fire;

  assign keyOk  = (wrData[15:8] == KEY_CODE);
  assign goodWr = wrEn & keyOk;
  assign badWr  = wrEn & ~keyOk;
  assign fire   = expire | badWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      actQ  <= 1'b0;
      srcQ  <= 1'b0;
      ivlQ  <= 2'd0;
    end else if (goodWr) begin
      holdQ <= wrData[HOLD_BIT];
      actQ  <= wrData[ACT_BIT];
      srcQ  <= wrData[SRC_BIT];
      ivlQ  <= wrData[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstOut  <= 1'b0;
      nmiOut  <= 1'b0;
      keyViol <= 1'b0;
    end else begin
      rstOut  <= fire & ~actQ;
      nmiOut  <= fire & actQ;
      keyViol <= badWr;
    end
  end

  always_comb begin
    ctl.clrCnt  = goodWr & wrData[CLR_BIT];
    ctl.runEn   = ~holdQ;
    ctl.useSrcB = srcQ;
    ctl.ivlSel  = ivlQ;
  end

  assign rdData = {READ_TAG, holdQ, 2'b00, actQ, 1'b0, srcQ, ivlQ};

  // R4
  bad_key_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    badWr |=> ($stable(rdData) && keyViol));

  // R3
  good_key_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    goodWr |=> (rdData[7:0] == ($past(wrData[7:0]) & 8'h97)));

  // R5
  viol_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyViol |-> (rstOut ^ nmiOut));

  // R11
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rstOut && nmiOut));

  // R8
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (rstOut || nmiOut));

endmodule

// File: rtl/kwdTimer.sv
module kwdTimer
  import kwdPkg::*;
#(
  parameter int         CNT_W    = 16,
  parameter int         TAP_E0   = 15,
  parameter int         TAP_E1   = 13,
  parameter int         TAP_E2   = 9,
  parameter int         TAP_E3   = 6,
  parameter logic [7:0] KEY_CODE = 8'h5A,
  parameter logic [7:0] READ_TAG = 8'h69
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcAEn,
  input  logic        srcBEn,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        rstOut,
  output logic        nmiOut,
  output logic        keyViol
);

  cntCtl_t cntCtl;
  logic    expire;

  kwdCtrl #(
    .KEY_CODE(KEY_CODE),
    .READ_TAG(READ_TAG)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .expire (expire),
    .ctl    (cntCtl),
    .rdData (rdData),
    .rstOut (rstOut),
    .nmiOut (nmiOut),
    .keyViol(keyViol)
  );

  kwdCount #(
    .CNT_W (CNT_W),
    .TAP_E0(TAP_E0),
    .TAP_E1(TAP_E1),
    .TAP_E2(TAP_E2),
    .TAP_E3(TAP_E3)
  ) u_count (
    .clk   (clk),
    .rstN  (rstN),
    .srcAEn(srcAEn),
    .srcBEn(srcBEn),
    .ctl   (cntCtl),
    .expire(expire)
  );

endmodule

// File: tb/kwdTimer_test.sv
module kwdTimer_test;

  localparam int E0 = 7;
  localparam int E1 = 5;
  localparam int E2 = 3;
  localparam int E3 = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcAEn = 1'b0;
  logic        srcBEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rstOut;
  logic        nmiOut;
  logic        keyViol;

  int total = 0;
  int bad = 0;

  kwdTimer #(
    .CNT_W(16), .TAP_E0(E0), .TAP_E1(E1), .TAP_E2(E2), .TAP_E3(E3)
  ) uut (
    .clk(clk), .rstN(rstN), .srcAEn(srcAEn), .srcBEn(srcBEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rstOut(rstOut), .nmiOut(nmiOut), .keyViol(keyViol)
  );

  always #10 clk = ~clk;

  function automatic int tapOf(input int ivl);
    case (ivl)
      0: return 1 << E0;
      1: return 1 << E1;
      2: return 1 << E2;
      default: return 1 << E3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write takes effect at the following posedge.
  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Counts ticks until a pulse appears on the selected action output.
  task automatic waitPulse(input bit useNmi, input int limit, output int hit, output int wrongHits);
    hit = 0;
    wrongHits = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if ((useNmi ? nmiOut : rstOut) && hit == 0) hit = k;
      if (useNmi ? rstOut : nmiOut) wrongHits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hit;
    int wrong;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(rdData == 16'h6900, "R1 reset read", rdData, 16'h6900);
    chk(!rstOut && !nmiOut && !keyViol, "R1 outputs idle", {rstOut, nmiOut, keyViol}, 0);

    // R1: default interval, source A, reset action
    rstN = 1'b1;
    srcAEn = 1'b1;
    waitPulse(1'b0, tapOf(0) + 2, hit, wrong);
    chk(hit == tapOf(0), "R1 default expiry tick", hit, tapOf(0));
    chk(wrong == 0, "R1 no interrupt in reset mode", wrong, 0);
    srcAEn = 1'b0;
    @(negedge clk);

    // R2/R3: keyed write and read format
    wr(16'h5AFF);
    chk(rdData == 16'h6997, "R2 R3 read format", rdData, 16'h6997);

    // R4/R5: wrong key with interrupt action
    wr(16'hA512);
    chk(keyViol == 1'b1, "R4 violation pulse", keyViol, 1);
    chk(nmiOut && !rstOut, "R5 interrupt on bad key", {rstOut, nmiOut}, 1);
    chk(rdData == 16'h6997, "R4 register kept", rdData, 16'h6997);
    @(negedge clk);
    chk(!keyViol && !nmiOut, "R4 one-cycle pulse", {keyViol, nmiOut}, 0);

    // R4/R5: near-miss key with reset action
    wr(16'h5A00);
    wr(16'h5B08);
    chk(keyViol && rstOut && !nmiOut, "R5 reset on bad key", {keyViol, rstOut, nmiOut}, 6);
    chk(rdData == 16'h6900, "R4 register kept 2", rdData, 16'h6900);
    @(negedge clk);

    // R6 R7 R8 R9 R11: sweep interval x action x source
    for (int ivl = 0; ivl < 4; ivl++) begin
      for (int act = 0; act < 2; act++) begin
        for (int src = 0; src < 2; src++) begin
          int n;
          int first;
          int second;
          int w1;
          int w2;
          n = tapOf(ivl);
          srcAEn = 1'b0;
          srcBEn = 1'b0;
          wr(16'h5A08 | 16'(act << 4) | 16'(src << 2) | 16'(ivl));
          if (src == 1) srcBEn = 1'b1; else srcAEn = 1'b1;
          waitPulse(act[0], n, first, w1);
          waitPulse(act[0], n, second, w2);
          chk(first == n, "R7 first expiry tick", first, n);
          chk(second == n, "R8 restart interval", second, n);
          chk(w1 + w2 == 0, "R11 wrong action output", w1 + w2, 0);
        end
      end
    end
    srcAEn = 1'b0;
    srcBEn = 1'b0;
    @(negedge clk);

    // R8: pulse width is one cycle
    wr(16'h5A0B);
    srcAEn = 1'b1;
    waitPulse(1'b0, tapOf(3), hit, wrong);
    @(negedge clk);
    chk(!rstOut, "R8 pulse one cycle", rstOut, 0);

    // R10: hold freezes the count
    srcAEn = 1'b0;
    wr(16'h5A0A);
    srcAEn = 1'b1;
    repeat (5) @(negedge clk);
    srcAEn = 1'b0;
    wr(16'h5A82);
    srcAEn = 1'b1;
    waitPulse(1'b0, 20, hit, wrong);
    chk(hit == 0 && wrong == 0, "R10 no expiry on hold", hit, 0);
    srcAEn = 1'b0;
    wr(16'h5A02);
    srcAEn = 1'b1;
    waitPulse(1'b0, 4, hit, wrong);
    chk(hit == tapOf(2) - 5, "R10 resume from held count", hit, tapOf(2) - 5);

    // R6: unselected source ignored
    srcAEn = 1'b0;
    wr(16'h5A0B);
    srcBEn = 1'b1;
    waitPulse(1'b0, 40, hit, wrong);
    chk(hit == 0 && wrong == 0, "R6 other source ignored", hit, 0);
    srcBEn = 1'b0;
    srcAEn = 1'b1;
    waitPulse(1'b0, tapOf(3), hit, wrong);
    chk(hit == tapOf(3), "R6 count untouched", hit, tapOf(3));

    // R9: a clear write restarts a partly advanced count
    srcAEn = 1'b0;
    wr(16'h5A0A);
    srcAEn = 1'b1;
    repeat (6) @(negedge clk);
    wr(16'h5A0A);
    waitPulse(1'b0, tapOf(2), hit, wrong);
    chk(hit == tapOf(2), "R9 clear restarts count", hit, tapOf(2));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule